// File: doc/BRIEF.md
# Power-On Strap Sampling Controller

After power comes up, this block decides how a group of dual-purpose pins behaves. Each pin is an input while strap resistors settle it, and a clock output after that. While the supply is good but the sampling window has not yet expired, every shared pin keeps its output driver off. Only the board's pull resistors set the pin levels during this time. When a reference-clock counter reaches its terminal count, the block captures the synchronised pin levels into a configuration register. One clock later it turns all the drivers on. The captured value stays in place until power-good drops, which models a full power cycle.

The captured word has two parts. Four frequency-select bits go to the frequency-table logic elsewhere in the chip. One mode bit decides the role of a separate shared pin. That pin is either a stop-request input for the bus clocks (mode 0) or a reference-clock output (mode 1). The block produces the two qualified enables for that pin. Every output here is a plain level, so no handshake is involved.

Top module: `strap_seq_ctrl`

## Requirements
- R1: While power-good is high and fewer than WIN_CYCLES reference-clock edges have passed since it rose, `pad_oe` is all zeros, and `cfg_valid`, `fs_sel` and `mode_sel` are zero.
- R2: At the WIN_CYCLES-th rising edge after power-good rises, the block captures the pin levels: `fs_sel[i]` takes `pad_in[i]` for i = 0..3, and `mode_sel` takes `pad_in[4]`. This holds when the pins have been steady for at least SYNC_STAGES cycles before that edge.
- R3: `pad_oe` turns all ones exactly one edge after `cfg_valid` rises, and stays all ones while power-good is high.
- R4: After the capture, changes on `pad_in` have no effect on `fs_sel`, `mode_sel`, `cfg_valid` or `pad_oe`.
- R5: With the drivers on, `ref_out_en` equals `mode_sel` and `stop_in_sel` equals its inverse. Before the drivers turn on, both are 0.
- R6: When power-good goes low, every output clears at once, with no clock needed. When power-good rises again, a fresh window starts and the pins are sampled anew.
- R7: `cfg_valid` rises after exactly WIN_CYCLES edges, never sooner and never later. WIN_CYCLES is a parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the window |
| pwr_ok | input | 1 | Power-good; low acts as an asynchronous clear (power cycle) |
| pad_in | input | N_FS+1 | Pin levels; bits 0..3 are the frequency selects, bit 4 is the mode strap |
| pad_oe | output | N_FS+1 | Driver enables for the shared pins, one per pin |
| fs_sel | output | N_FS | Captured frequency-select bits |
| mode_sel | output | 1 | Captured mode bit |
| cfg_valid | output | 1 | The captured bits are valid |
| ref_out_en | output | 1 | The mode pin drives the reference clock |
| stop_in_sel | output | 1 | The mode pin acts as the stop-request input |

## Verification
The captured bits are due at the WIN_CYCLES-th edge after power-good rises. The driver enables and the mode-pin enables follow one edge later. A power-good drop clears the outputs at once. The bench keeps an edge count since power-good rose, derives each output's expected value from that count, and compares at every falling clock edge. The falling edge is half a period away from the edge that updates the outputs. Strap changes are applied just after a rising edge, always long before or after the capture, so the synchroniser latency never makes the expected value ambiguous.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_LATCH  = 2'd1,
    PH_DRIVE  = 2'd2
  } strap_phase_t;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sh [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[g] <= '0;
      else if (g == 0) sh[g] <= d;
      else sh[g] <= sh[(g == 0) ? 0 : g-1];
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int WIN_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expire
);
  localparam int CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign expire = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (en && !expire) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/strap_seq_ctrl.sv
module strap_seq_ctrl
  import strap_pkg::*;
#(
  parameter int N_FS        = 4,
  parameter int WIN_CYCLES  = 28636,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            pwr_ok,
  input  logic [N_FS:0]   pad_in,
  output logic [N_FS:0]   pad_oe,
  output logic [N_FS-1:0] fs_sel,
  output logic            mode_sel,
  output logic            cfg_valid,
  output logic            ref_out_en,
  output logic            stop_in_sel
);
  localparam int NPIN = N_FS + 1;

  strap_phase_t phase;
  logic [NPIN-1:0] pad_s;
  logic [NPIN-1:0] cfg_q;
  logic            expire;
  logic            drive;

  strap_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(pwr_ok), .d(pad_in), .q(pad_s)
  );

  strap_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk(clk), .rst_n(pwr_ok), .en(phase == PH_SAMPLE), .expire(expire)
  );

  strap_capture #(.W(NPIN)) u_cap (
    .clk(clk), .rst_n(pwr_ok), .cap(expire), .d(pad_s), .q(cfg_q)
  );

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) phase <= PH_SAMPLE;
    else begin
      case (phase)
        PH_SAMPLE: if (expire) phase <= PH_LATCH;
        PH_LATCH:  phase <= PH_DRIVE;
        default:   phase <= PH_DRIVE;
      endcase
    end
  end

  assign drive       = (phase == PH_DRIVE);
  assign cfg_valid   = (phase != PH_SAMPLE);
  assign pad_oe      = {NPIN{drive}};
  assign fs_sel      = cfg_q[N_FS-1:0];
  assign mode_sel    = cfg_q[N_FS];
  assign ref_out_en  = drive && cfg_q[N_FS];
  assign stop_in_sel = drive && !cfg_q[N_FS];
endmodule

// File: rtl/strap_seq_chk.sv
module strap_seq_chk #(
  parameter int N_FS       = 4,
  parameter int WIN_CYCLES = 28636
) (
  input logic            clk,
  input logic            pwr_ok,
  input logic [N_FS:0]   pad_oe,
  input logic [N_FS-1:0] fs_sel,
  input logic            mode_sel,
  input logic            cfg_valid,
  input logic            ref_out_en,
  input logic            stop_in_sel
);
  int unsigned cyc;

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) cyc <= 0;
    else if (cyc < WIN_CYCLES + 4) cyc <= cyc + 1;
  end

  p_quiet_window_r1: assert property (@(posedge clk) disable iff (!pwr_ok)
    !cfg_valid |-> (pad_oe == '0 && fs_sel == '0 && !mode_sel));

  p_oe_follows_latch_r3: assert property (@(posedge clk) disable iff (!pwr_ok)
    $rose(cfg_valid) |=> (&pad_oe));

  p_oe_needs_latch_r3: assert property (@(posedge clk) disable iff (!pwr_ok)
    $rose(pad_oe[0]) |-> $past(cfg_valid));

  p_oe_sticky_r3: assert property (@(posedge clk) disable iff (!pwr_ok)
    pad_oe[0] |=> (&pad_oe));

  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!pwr_ok)
    (cfg_valid && $past(cfg_valid)) |-> ($stable(fs_sel) && $stable(mode_sel) && cfg_valid));

  p_mode_pin_r5: assert property (@(posedge clk) disable iff (!pwr_ok)
    $countones({ref_out_en, stop_in_sel}) == (pad_oe[N_FS] ? 1 : 0));

  p_ref_mode_r5: assert property (@(posedge clk) disable iff (!pwr_ok)
    ref_out_en |-> mode_sel);

  p_window_len_r7: assert property (@(posedge clk) disable iff (!pwr_ok)
    $rose(cfg_valid) |-> (cyc == WIN_CYCLES));
endmodule

bind strap_seq_ctrl strap_seq_chk #(.N_FS(N_FS), .WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk(clk), .pwr_ok(pwr_ok), .pad_oe(pad_oe), .fs_sel(fs_sel),
  .mode_sel(mode_sel), .cfg_valid(cfg_valid), .ref_out_en(ref_out_en),
  .stop_in_sel(stop_in_sel)
);

// File: tb/sim_strap_seq_ctrl.sv
`timescale 1ns/1ps
module sim_strap_seq_ctrl;
  localparam int WIN = 20;

  logic       clk = 1'b0;
  logic       pwr_ok = 1'b0;
  logic [4:0] pad_in = '0;
  logic [4:0] pad_oe;
  logic [3:0] fs_sel;
  logic       mode_sel, cfg_valid, ref_out_en, stop_in_sel;

  int checks = 0;
  int fails = 0;
  int n = 0;
  logic [4:0] m_lat = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  strap_seq_ctrl #(.N_FS(4), .WIN_CYCLES(WIN), .SYNC_STAGES(2)) u0 (
    .clk(clk), .pwr_ok(pwr_ok), .pad_in(pad_in), .pad_oe(pad_oe),
    .fs_sel(fs_sel), .mode_sel(mode_sel), .cfg_valid(cfg_valid),
    .ref_out_en(ref_out_en), .stop_in_sel(stop_in_sel)
  );

  // Reference model: edge count since power-good rose
  always @(posedge clk) begin
    if (!pwr_ok) begin
      n = 0;
      m_lat = '0;
    end else begin
      n = n + 1;
      if (n == WIN) m_lat = pad_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at t=%0t n=%0d: actual %0h expected %0h", tag, $time, n, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      logic       e_val, e_oe;
      logic [4:0] e_cfg;
      e_val = pwr_ok && (n >= WIN);
      e_oe  = pwr_ok && (n >= WIN + 1);
      e_cfg = e_val ? m_lat : 5'd0;
      chk("R7 R1 R6 cfg_valid", 32'(cfg_valid), 32'(e_val));
      chk("R3 R1 pad_oe", 32'(pad_oe), e_oe ? 32'h1f : 32'h0);
      chk("R2 R4 fs_sel/mode_sel", 32'({mode_sel, fs_sel}), 32'(e_cfg));
      chk("R5 ref/stop", 32'({ref_out_en, stop_in_sel}),
          32'({e_oe && e_cfg[4], e_oe && !e_cfg[4]}));
    end
  end

  task automatic power_up(input logic [4:0] straps);
    @(posedge clk); #1;
    pwr_ok = 1'b0;
    pad_in = straps;
    repeat (3) @(posedge clk);
    #1 pwr_ok = 1'b1;
    repeat (WIN + 4) @(posedge clk);
    #1;
  endtask

  initial begin
    // R1 R6: reset state before any power-up
    #3;
    chk("R6 reset pad_oe", 32'(pad_oe), 32'h0);
    chk("R6 reset cfg", 32'({cfg_valid, mode_sel, fs_sel}), 32'h0);

    // Run 1: mode 1, fs = 6 (R2, R5 reference output)
    power_up(5'b1_0110);
    chk("R2 fs_sel run1", 32'(fs_sel), 32'h6);
    chk("R5 ref_out_en run1", 32'(ref_out_en), 32'h1);

    // R4: strap changes after capture are ignored
    for (int k = 0; k < 8; k++) begin
      pad_in = 5'(k * 7 + 3);
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R4 fs_sel held", 32'({mode_sel, fs_sel}), 32'h16);

    // R6: power-good drop clears at once
    pwr_ok = 1'b0;
    #0.5;
    chk("R6 async clear", 32'({pad_oe, cfg_valid, ref_out_en}), 32'h0);

    // Run 2: mode 0, fs = 9 (R5 stop input)
    power_up(5'b0_1001);
    chk("R2 fs_sel run2", 32'(fs_sel), 32'h9);
    chk("R5 stop_in_sel run2", 32'(stop_in_sel), 32'h1);

    // Runs 3 and 4: all ones, all zeros
    power_up(5'b1_1111);
    chk("R2 all ones", 32'({mode_sel, fs_sel}), 32'h1f);
    power_up(5'b0_0000);
    chk("R2 all zeros", 32'({cfg_valid, mode_sel, fs_sel}), 32'h20);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule